// File: doc/BRIEF.md
# Bit-Clock Recovery Loop with Stepped Bandwidth

This block rebuilds a bit clock from a baseband stream that has already been hard-sliced to one bit and is oversampled. A strobe marks each oversampling tick. A phase counter advances on every tick and wraps once per bit. A change of the sliced bit between two ticks counts as a zero crossing. Where the counter sits when a crossing arrives is the timing error, and that error steers the counter. Downstream logic gets four things: a recovered clock whose rising edge falls mid-bit, a strobe at that sampling point, a strobe for each crossing, and the counter value itself. The counter value shows where the next expected crossing lies.

Two inputs and an internal bit timer choose how hard the loop pulls. The first input is an acquire control. The second is an active-low hold control. The four loop modes are the states of a small machine:
- ACQ (wide): every crossing snaps the phase at once.
- MED (medium): a timed phase that allows at most 1/16 bit of correction per pair of crossings.
- NAR (narrow): allows at most 1/64 bit per pair.
- HOLD: the loop is opened and the clock freewheels.

The transitions are named as follows:
- ACQ_ENTER: any state goes to ACQ while acquire is high.
- HOLD_ENTER: any state goes to HOLD while acquire is low and hold is asserted.
- ACQ_RELEASE: ACQ goes to MED.
- MED_EXPIRE: MED goes to NAR once 30 bits have passed.
- HOLD_RESUME_MED: HOLD goes back to MED when the timer has not finished.
- HOLD_RESUME_NAR: HOLD goes back to NAR when the timer has finished.

A typical receiver raises acquire during a preamble and lowers it once lock is reached. It asserts hold during a fade.

Top module: `bcr_dpll`

## Requirements
- R1: After reset, `bit_phase` is 0, `bclk` is 0, `samp_stb` and `zc_stb` are 0, and the machine is in ACQ with the bit timer at 0.
- R2: `bit_phase` changes only in the clock cycle after a tick. `bclk` is high exactly while `bit_phase` is 64 to 127, which gives 50% duty. This holds in every mode, including HOLD.
- R3: `samp_stb` is a one-cycle pulse that appears in the same cycle as each rising edge of `bclk`. That edge is the mid-bit sampling point. `bit_phase` 0 marks the expected crossing.
- R4: `zc_stb` pulses for one cycle after any tick on which `din` differs from its value at the previous tick. The reference value at reset is 0.
- R5: While `acq` is high, each crossing applies its full error, so `bit_phase` becomes 1 after that tick. `hold_n` has no effect. The error is `bit_phase` read as a signed 7-bit value (−64..63) on the crossing tick. The new phase is old + 1 − correction, modulo 128.
- R6: Outside ACQ and HOLD, crossing errors are handled in pairs. The first crossing stores its error and applies nothing. The second crossing applies the sum of the two errors, clamped to ±8 ticks in MED and in the single transitional cycle after acquire falls.
- R7: The bit timer is cleared while `acq` is high. In MED it counts `samp_stb` pulses. When it reaches 30, the machine moves to NAR (MED_EXPIRE).
- R8: In NAR, the clamp on the summed pair error is ±2 ticks.
- R9: With `acq` low and `hold_n` low, crossings apply no correction. The pending half of a pair is dropped and the timer pauses. On release, the machine returns to MED if the timer is below 30 and to NAR otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Oversampling tick, one per phase step |
| din | input | 1 | Hard-sliced received bit, read on ticks |
| acq | input | 1 | High selects wide acquisition |
| hold_n | input | 1 | Low opens the loop when acq is low |
| bclk | output | 1 | Recovered bit clock, rising at mid-bit |
| samp_stb | output | 1 | One-cycle pulse at each bclk rising edge |
| zc_stb | output | 1 | One-cycle pulse per detected crossing |
| bit_phase | output | PH_W | Phase within the bit; 0 is the expected crossing |

## Verification
The bench moves the far-end transmitter's phase by large steps in each mode and watches the size of each correction. A loop with a wrong clamp would move the phase by the full error, or by the other mode's limit, where the limit should apply. Acquire is raised while hold is asserted, to show that hold is ignored there; a design that honoured hold would let the phase freewheel instead of snapping to 1. Hold is also asserted in the middle of the medium window. If the timer did not pause, the narrow limit would arrive too early. If the machine resumed in the wrong mode, the first pair after release would be corrected by the wrong amount. Each pair is checked alone, so a design that applied single crossings would show corrections on odd crossings.

// File: rtl/bcr_pkg.sv
`timescale 1ns/1ps
package bcr_pkg;
    typedef enum logic [1:0] {
        MD_ACQ  = 2'd0,
        MD_MED  = 2'd1,
        MD_NAR  = 2'd2,
        MD_HOLD = 2'd3
    } mode_e;
endpackage

// File: rtl/bcr_mode_fsm.sv
`timescale 1ns/1ps
module bcr_mode_fsm #(
    parameter int MED_BITS = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acq,
    input  logic          hold_n,
    input  logic          bit_evt,
    output bcr_pkg::mode_e mode_q,
    output logic          narrow
);
    import bcr_pkg::*;
    localparam int CW = $clog2(MED_BITS + 1);

    mode_e          mode_nx;
    logic [CW-1:0]  cnt_q;
    logic           done;

    assign done = (cnt_q == CW'(MED_BITS));

    // next-state selection
    always_comb begin
        mode_nx = mode_q;
        if (acq) begin
            mode_nx = MD_ACQ;                       // ACQ_ENTER
        end else if (!hold_n) begin
            mode_nx = MD_HOLD;                      // HOLD_ENTER
        end else begin
            unique case (mode_q)
                MD_ACQ:  mode_nx = MD_MED;          // ACQ_RELEASE
                MD_MED:  mode_nx = done ? MD_NAR : MD_MED;   // MED_EXPIRE
                MD_NAR:  mode_nx = MD_NAR;
                MD_HOLD: mode_nx = done ? MD_NAR : MD_MED;   // HOLD_RESUME_*
                default: mode_nx = MD_ACQ;
            endcase
        end
    end

    // state register and bit timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_ACQ;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_nx;
            if (acq)
                cnt_q <= '0;
            else if (mode_q == MD_MED && bit_evt && !done)
                cnt_q <= cnt_q + CW'(1);
        end
    end

    // outputs
    always_comb begin
        narrow = (mode_q == MD_NAR);
    end
endmodule

// File: rtl/bcr_xing_det.sv
`timescale 1ns/1ps
module bcr_xing_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic xing,
    output logic zc_q
);
    logic din_q;

    assign xing = tick && (din != din_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_q <= 1'b0;
            zc_q  <= 1'b0;
        end else begin
            zc_q <= xing;
            if (tick)
                din_q <= din;
        end
    end
endmodule

// File: rtl/bcr_phase_loop.sv
`timescale 1ns/1ps
module bcr_phase_loop #(
    parameter int PH_W    = 7,
    parameter int MED_LIM = 8,
    parameter int NAR_LIM = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            xing,
    input  logic            acq,
    input  logic            hold_n,
    input  logic            narrow,
    output logic [PH_W-1:0] ph_q,
    output logic            samp_q
);
    localparam int SW = PH_W + 1;

    logic signed [SW-1:0] err_x, acc_q, sum, corr, lim;
    logic                 half_q;
    logic [PH_W-1:0]      ph_nx;

    assign err_x = $signed({ph_q[PH_W-1], ph_q});
    assign sum   = acc_q + err_x;
    assign lim   = narrow ? SW'(NAR_LIM) : SW'(MED_LIM);

    always_comb begin
        corr = '0;
        if (xing) begin
            if (acq) begin
                corr = err_x;
            end else if (hold_n && half_q) begin
                if (sum > lim)
                    corr = lim;
                else if (sum < -lim)
                    corr = -lim;
                else
                    corr = sum;
            end
        end
        ph_nx = ph_q + PH_W'(1) - corr[PH_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= '0;
            samp_q <= 1'b0;
            acc_q  <= '0;
            half_q <= 1'b0;
        end else begin
            samp_q <= tick && ph_nx[PH_W-1] && !ph_q[PH_W-1];
            if (tick)
                ph_q <= ph_nx;
            if (acq || !hold_n) begin
                acc_q  <= '0;
                half_q <= 1'b0;
            end else if (xing) begin
                acc_q  <= half_q ? '0 : err_x;
                half_q <= !half_q;
            end
        end
    end
endmodule

// File: rtl/bcr_dpll.sv
`timescale 1ns/1ps
module bcr_dpll #(
    parameter int PH_W     = 7,
    parameter int MED_BITS = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_stb,
    input  logic            din,
    input  logic            acq,
    input  logic            hold_n,
    output logic            bclk,
    output logic            samp_stb,
    output logic            zc_stb,
    output logic [PH_W-1:0] bit_phase
);
    localparam int PERIOD  = 1 << PH_W;
    localparam int MED_LIM = PERIOD / 16;
    localparam int NAR_LIM = PERIOD / 64;

    bcr_pkg::mode_e mode_q;
    logic           narrow;
    logic           xing;

    bcr_xing_det u_xing (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (smp_stb),
        .din   (din),
        .xing  (xing),
        .zc_q  (zc_stb)
    );

    bcr_phase_loop #(
        .PH_W    (PH_W),
        .MED_LIM (MED_LIM),
        .NAR_LIM (NAR_LIM)
    ) u_loop (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (smp_stb),
        .xing   (xing),
        .acq    (acq),
        .hold_n (hold_n),
        .narrow (narrow),
        .ph_q   (bit_phase),
        .samp_q (samp_stb)
    );

    bcr_mode_fsm #(
        .MED_BITS (MED_BITS)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .acq     (acq),
        .hold_n  (hold_n),
        .bit_evt (samp_stb),
        .mode_q  (mode_q),
        .narrow  (narrow)
    );

    assign bclk = bit_phase[PH_W-1];
endmodule

// File: rtl/bcr_dpll_chk.sv
`timescale 1ns/1ps
module bcr_dpll_chk #(
    parameter int PH_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            smp_stb,
    input logic            acq,
    input logic            hold_n,
    input logic            bclk,
    input logic            samp_stb,
    input logic            zc_stb,
    input logic [PH_W-1:0] bit_phase,
    input bcr_pkg::mode_e  mode
);
    localparam int P = 1 << PH_W;
    localparam int ML = P / 16;
    localparam int NL = P / 64;

    logic [PH_W-1:0] prev_ph;
    logic [PH_W-1:0] step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_ph <= '0;
        else        prev_ph <= bit_phase;
    end
    assign step = bit_phase - prev_ph - PH_W'(1);

    // R2: phase moves only after a tick
    a_r2_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_stb) |-> $stable(bit_phase));

    // R3: sample strobe coincides with bclk rising
    a_r3_samp_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb |-> $rose(bclk));

    // R5: acquire snaps phase to 1 on every crossing
    a_r5_acq_snap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acq) && zc_stb) |-> (bit_phase == PH_W'(1)));

    // R6: correction never exceeds the medium clamp outside acquire
    a_r6_med_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_stb && !$past(acq)) |-> (step <= PH_W'(ML) || step >= PH_W'(P - ML)));

    // R8: narrow clamp
    a_r8_nar_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_stb && $past(mode == bcr_pkg::MD_NAR && !acq && hold_n))
            |-> (step <= PH_W'(NL) || step >= PH_W'(P - NL)));

    // R9: hold freewheels through crossings
    a_r9_hold_free: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_stb && $past(!acq && !hold_n)) |-> (step == '0));
endmodule

bind bcr_dpll bcr_dpll_chk #(.PH_W(PH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_stb   (smp_stb),
    .acq       (acq),
    .hold_n    (hold_n),
    .bclk      (bclk),
    .samp_stb  (samp_stb),
    .zc_stb    (zc_stb),
    .bit_phase (bit_phase),
    .mode      (mode_q)
);

// File: tb/bcr_dpll_test.sv
`timescale 1ns/1ps
module bcr_dpll_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_stb = 1'b0;
    logic       din = 1'b0;
    logic       acq = 1'b0;
    logic       hold_n = 1'b1;
    logic       bclk, samp_stb, zc_stb;
    logic [6:0] bit_phase;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bcr_dpll uut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .din(din),
        .acq(acq), .hold_n(hold_n), .bclk(bclk), .samp_stb(samp_stb),
        .zc_stb(zc_stb), .bit_phase(bit_phase)
    );

    // ---------------- behavioural reference model ----------------
    localparam int M_ACQ = 0, M_MED = 1, M_NAR = 2, M_HOLD = 3;
    int  m_ph, m_mode, m_cnt, m_acc;
    bit  m_din, m_half, m_samp, m_zc;
    int  t_err, t_corr, t_sum, t_lim, t_nph, t_nmode;
    bit  t_x;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_mode = M_ACQ; m_cnt = 0; m_acc = 0;
            m_din = 0; m_half = 0; m_samp = 0; m_zc = 0;
        end else begin
            t_x    = smp_stb && (din != m_din);
            t_err  = (m_ph >= 64) ? m_ph - 128 : m_ph;
            t_lim  = (m_mode == M_NAR) ? 2 : 8;
            t_corr = 0;
            if (t_x) begin
                if (acq) t_corr = t_err;
                else if (hold_n && m_half) begin
                    t_sum  = m_acc + t_err;
                    t_corr = (t_sum > t_lim) ? t_lim : ((t_sum < -t_lim) ? -t_lim : t_sum);
                end
            end
            t_nph = smp_stb ? (((m_ph + 1 - t_corr) % 128) + 128) % 128 : m_ph;
            // mode machine
            if (acq) t_nmode = M_ACQ;
            else if (!hold_n) t_nmode = M_HOLD;
            else if (m_mode == M_ACQ) t_nmode = M_MED;
            else if (m_mode == M_NAR) t_nmode = M_NAR;
            else t_nmode = (m_cnt >= 30) ? M_NAR : M_MED;
            if (acq) m_cnt = 0;
            else if (m_mode == M_MED && m_samp && m_cnt < 30) m_cnt = m_cnt + 1;
            // pairing
            if (acq || !hold_n) begin m_half = 0; m_acc = 0; end
            else if (t_x) begin
                if (m_half) begin m_half = 0; m_acc = 0; end
                else begin m_half = 1; m_acc = t_err; end
            end
            m_samp = smp_stb && (t_nph >= 64) && (m_ph < 64);
            m_zc   = t_x;
            if (smp_stb) m_din = din;
            m_ph   = t_nph;
            m_mode = t_nmode;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(int'(bit_phase) == m_ph,
                (m_mode == M_ACQ) ? "R5 phase" : (m_mode == M_MED) ? "R6 phase" :
                (m_mode == M_NAR) ? "R8/R7 phase" : "R9 phase", bit_phase, m_ph);
            chk(bclk == (m_ph >= 64), "R2 bclk", bclk, m_ph >= 64);
            chk(samp_stb == m_samp, "R3 samp_stb", samp_stb, m_samp);
            chk(zc_stb == m_zc, "R4 zc_stb", zc_stb, m_zc);
        end
    end

    // ---------------- far-end transmitter ----------------
    int  tx_cnt = 0, tx_off = 37, nbits = 0;
    bit  tgl = 0, pre = 1;
    logic [8:0] lfsr = 9'h1A5;

    task automatic step_clk();
        @(negedge clk);
        tgl = !tgl;
        smp_stb = tgl;
        if (tgl) begin
            tx_cnt++;
            if (((tx_cnt + tx_off) % 128) == 0) begin
                nbits++;
                if (pre) din = ((nbits % 4) < 2);
                else begin
                    lfsr = {lfsr[7:0], lfsr[8] ^ lfsr[4]};
                    din = lfsr[0];
                end
            end
        end
    endtask

    task automatic run_bits(input int nb);
        repeat (nb * 256) step_clk();
    endtask

    task automatic shift_tx(input int d);
        tx_off = ((tx_off + d) % 128 + 128) % 128;
    endtask

    // directed: size of the correction seen at each crossing
    int obs_lim = -1;      // -1: not checking
    string obs_tag;
    int max_step = 0;
    logic [6:0] prev_bp = 0;
    always @(negedge clk) begin
        int d;
        if (rst_n && zc_stb && obs_lim >= 0) begin
            d = (int'(bit_phase) - int'(prev_bp) - 1 + 256) % 128;
            if (d >= 64) d = d - 128;
            if (d > max_step) max_step = d;
            if (-d > max_step) max_step = -d;
            chk(d <= obs_lim && d >= -obs_lim, obs_tag, d, obs_lim);
        end
        prev_bp = bit_phase;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bit_phase == 0, "R1 phase", bit_phase, 0);
        chk(bclk == 0, "R1 bclk", bclk, 0);
        chk(samp_stb == 0 && zc_stb == 0, "R1 strobes", samp_stb, 0);
        rst_n = 1'b1;
        acq = 1'b1;
        run_bits(20);                    // R5 acquire with preamble
        pre = 0;
        acq = 1'b0;                      // medium
        run_bits(6);
        obs_tag = "R6 med clamp"; obs_lim = 8; max_step = 0;
        shift_tx(40);
        run_bits(10);
        chk(max_step == 8, "R6 clamp reached", max_step, 8);
        obs_lim = -1;
        hold_n = 1'b0;                   // R9 hold mid-medium
        obs_tag = "R9 hold"; obs_lim = 0;
        shift_tx(-30);
        run_bits(6);
        obs_lim = -1;
        hold_n = 1'b1;                   // resume medium, timer paused
        obs_tag = "R9/R7 resume med"; obs_lim = 8; max_step = 0;
        run_bits(8);
        chk(max_step == 8, "R7 still medium after hold", max_step, 8);
        obs_lim = -1;
        run_bits(20);                    // timer expires -> narrow
        obs_tag = "R8 nar clamp"; obs_lim = 2; max_step = 0;
        shift_tx(30);
        run_bits(16);
        chk(max_step == 2, "R8 clamp reached", max_step, 2);
        obs_lim = -1;
        hold_n = 1'b0;                   // R5: hold ignored in acquire
        acq = 1'b1;
        shift_tx(50);
        run_bits(5);
        hold_n = 1'b1;
        acq = 1'b0;                      // R7 restart of medium
        obs_tag = "R7 restart med"; obs_lim = 8; max_step = 0;
        run_bits(4);
        shift_tx(-45);
        run_bits(10);
        chk(max_step == 8, "R7 medium after re-acquire", max_step, 8);
        obs_lim = -1;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule